// File: doc/BRIEF.md
# Byte-Lane Instruction Word Fetcher

This block builds 16-bit instruction words out of a byte-wide program store. A 256 x 8 synchronous RAM is read one byte per clock. The read address comes from an internal program counter. Each byte goes to one of two lane registers, chosen by the address parity. Bytes from even addresses always land in the high lane. Bytes from odd addresses always land in the low lane. The two lanes together form the 16-bit instruction output.

A word takes two RAM read cycles: the even byte is read first, then the odd byte. Because the RAM read is registered, the word appears on the output three clock edges after the request. If the fetch request is held high, the next word starts as soon as the current one finishes, giving one word every two cycles.

Before execution, a program is written into the RAM through a byte write port. Writes are accepted only while the fetcher is idle and no fetch is being requested. The surrounding control logic raises the fetch request only between instructions. It must never raise it while an instruction is still executing.

Top module: `dbf_fetch16`

## Requirements
- R1: A synchronous active-high reset sets the counter `pc` to 0 and sets `instr` to 0x0000. It also drives `instr_valid` and `busy` low.
- R2: When `wr_en` is high while `busy` and `fetch_en` are both low, the byte `wr_data` is stored at RAM address `wr_addr` on that clock edge.
- R3: A write request made while `busy` is high, or in the same cycle as `fetch_en`, is ignored and leaves the RAM contents unchanged.
- R4: `fetch_en` sampled high while `busy` is low starts a fetch. `busy` is then high for exactly two cycles. `instr_valid` is high for one cycle after the third edge, counting the request edge as the first.
- R5: A completed word carries the byte at even address `p` in `instr[15:8]` and the byte at odd address `p+1` in `instr[7:0]`. Here `p` is the counter value when the fetch started.
- R6: The counter advances by one per byte read. It is even whenever the block is idle, and it wraps from 255 to 0.
- R7: `instr` changes only on the edge that raises `instr_valid`. It holds its value in every other cycle, including while a fetch is in flight.
- R8: If `fetch_en` is high in the second busy cycle, the next fetch starts with no idle cycle. Held high, it yields one word every two cycles, with `instr_valid` never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Request to fetch the next 16-bit word |
| wr_en | input | 1 | Program-load write strobe |
| wr_addr | input | 8 | Program-load byte address |
| wr_data | input | 8 | Program-load byte |
| pc | output | 8 | Current fetch counter |
| busy | output | 1 | High while a fetch occupies the RAM read port |
| instr | output | 16 | Assembled instruction word (even byte high) |
| instr_valid | output | 1 | One-cycle pulse marking a newly completed word |

## Verification
The hardest case to reach from the ports is a streamed fetch that crosses the 255-to-0 wrap. That path needs many words in a row, with `fetch_en` held through every busy window and released at exactly the right busy cycle. The stimulus first loads all 256 bytes with distinct values. It then streams 128 words starting from address 8, so the counter passes the wrap mid-stream and comes back to 8. Each word is compared with a model of the RAM in the bench, and the bench checks that each pulse falls two cycles after the previous one. Blocked writes are aimed at the bytes the next fetch will read, so any leak would show up in that word.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } phase_t;
endpackage

// File: rtl/dbf_ram.sv
module dbf_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Plain single-clock RAM with registered read: infers block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbf_seq.sv
module dbf_seq
  import dbf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_en,
  output logic [AW-1:0] pc,
  output logic          busy,
  output logic          rd_en,
  output logic          cap_hi,
  output logic          cap_lo,
  output logic          wr_allow
);
  phase_t phase;
  logic   start;

  // A new word may begin from idle or from the last busy cycle.
  assign start    = fetch_en && (phase == PH_IDLE || phase == PH_LO);
  assign busy     = (phase != PH_IDLE);
  assign rd_en    = start || (phase == PH_HI);
  assign cap_hi   = (phase == PH_HI);
  assign cap_lo   = (phase == PH_LO);
  assign wr_allow = (phase == PH_IDLE) && !fetch_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      pc    <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_HI;
          pc    <= pc + 1'b1;
        end
        PH_HI: begin
          phase <= PH_LO;
          pc    <= pc + 1'b1;
        end
        PH_LO: if (start) begin
          phase <= PH_HI;
          pc    <= pc + 1'b1;
        end else begin
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbf_lanes.sv
module dbf_lanes #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_hi,
  input  logic          cap_lo,
  input  logic [DW-1:0] rd_byte,
  output logic [2*DW-1:0] word,
  output logic          word_valid
);
  logic [DW-1:0] stage_q;
  logic [DW-1:0] hi_q;
  logic [DW-1:0] lo_q;

  // Even byte waits in a stage so the visible word changes in one step.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q    <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= cap_lo;
      if (cap_hi) stage_q <= rd_byte;
      if (cap_lo) begin
        hi_q <= stage_q;
        lo_q <= rd_byte;
      end
    end
  end

  assign word = {hi_q, lo_q};
endmodule

// File: rtl/dbf_fetch16.sv
module dbf_fetch16 #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [ADDR_W-1:0]   pc,
  output logic                busy,
  output logic [2*BYTE_W-1:0] instr,
  output logic                instr_valid
);
  logic              rd_en;
  logic              cap_hi;
  logic              cap_lo;
  logic              wr_allow;
  logic [BYTE_W-1:0] rd_byte;

  dbf_seq #(.AW(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .fetch_en (fetch_en),
    .pc       (pc),
    .busy     (busy),
    .rd_en    (rd_en),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .wr_allow (wr_allow)
  );

  dbf_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (wr_en && wr_allow),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (pc),
    .rdata (rd_byte)
  );

  dbf_lanes #(.DW(BYTE_W)) u_lanes (
    .clk        (clk),
    .rst        (rst),
    .cap_hi     (cap_hi),
    .cap_lo     (cap_lo),
    .rd_byte    (rd_byte),
    .word       (instr),
    .word_valid (instr_valid)
  );
endmodule

// File: rtl/dbf_chk.sv
module dbf_chk #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                fetch_en,
  input logic [ADDR_W-1:0]   pc,
  input logic                busy,
  input logic [2*BYTE_W-1:0] instr,
  input logic                instr_valid
);
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (pc == '0 && instr == '0 && !instr_valid && !busy)); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && fetch_en) |=> busy); // R4

  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    instr_valid |-> $past(busy)); // R4

  AST_VALID_SPACED: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> !instr_valid); // R8

  AST_INSTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid && !$past(rst)) |-> $stable(instr)); // R7

  AST_IDLE_EVEN: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pc[0]); // R6

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!busy && fetch_en) |=> (pc == ADDR_W'($past(pc) + 1'b1))); // R6
endmodule

bind dbf_fetch16 dbf_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_en    (fetch_en),
  .pc          (pc),
  .busy        (busy),
  .instr       (instr),
  .instr_valid (instr_valid)
);

// File: tb/sim_dbf_fetch16.sv
module sim_dbf_fetch16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  pc;
  logic        busy;
  logic [15:0] instr;
  logic        instr_valid;

  logic [7:0] m [256];
  logic [7:0] exp_pc;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbf_fetch16 u0 (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pc(pc), .busy(busy),
    .instr(instr), .instr_valid(instr_valid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R1 pc", pc, 0);
    chk("R1 instr", instr, 0);
    chk("R1 valid", instr_valid, 0);
    chk("R1 busy", busy, 0);
    rst = 1'b0;
    step();
    chk("R1 pc after release", pc, 0);
  endtask

  task automatic t_load();
    for (int i = 0; i < 256; i++) begin
      m[i]    = 8'((i * 37 + 11) & 255);
      wr_en   = 1'b1;
      wr_addr = 8'(i);
      wr_data = m[i];
      step();
    end
    wr_en = 1'b0;
  endtask

  // One isolated fetch; checks timing, word content and counter.
  task automatic t_fetch_one(string tag);
    logic [15:0] prev;
    prev = instr;
    fetch_en = 1'b1;
    step();
    fetch_en = 1'b0;
    chk({tag, " R4 busy c1"}, busy, 1);
    chk({tag, " R4 valid c1"}, instr_valid, 0);
    chk({tag, " R7 hold c1"}, instr, prev);
    step();
    chk({tag, " R4 busy c2"}, busy, 1);
    chk({tag, " R7 hold c2"}, instr, prev);
    step();
    chk({tag, " R4 valid"}, instr_valid, 1);
    chk({tag, " R4 idle"}, busy, 0);
    chk({tag, " R5 word"}, instr, {m[exp_pc], m[8'(exp_pc + 1)]});
    exp_pc = exp_pc + 8'd2;
    chk({tag, " R6 pc"}, pc, exp_pc);
    prev = instr;
    step();
    chk({tag, " R4 pulse end"}, instr_valid, 0);
    chk({tag, " R7 hold after"}, instr, prev);
  endtask

  task automatic t_blocked_writes();
    // Target bytes 4 and 5, which the following fetch reads.
    fetch_en = 1'b1;
    wr_en    = 1'b1;
    wr_addr  = 8'd4;
    wr_data  = ~m[4];
    step();
    fetch_en = 1'b0;
    wr_addr  = 8'd5;
    wr_data  = ~m[5];
    step();
    step();
    wr_en = 1'b0;
    chk("R5 word 2/3", instr, {m[2], m[3]});
    exp_pc = exp_pc + 8'd2;
    step();
    t_fetch_one("R3 blocked writes ignored");
  endtask

  task automatic t_good_write();
    wr_en   = 1'b1;
    wr_addr = 8'd6;
    wr_data = 8'h5A;
    m[6]    = 8'h5A;
    step();
    wr_en = 1'b0;
    t_fetch_one("R2 accepted write");
  endtask

  task automatic t_stream();
    int got = 0;
    int gap = 0;
    logic [15:0] last;
    last = instr;
    fetch_en = 1'b1;
    while (got < 128) begin
      step();
      gap++;
      if (instr_valid) begin
        chk("R5 stream word", instr, {m[exp_pc], m[8'(exp_pc + 1)]});
        if (got > 0) chk("R8 spacing", gap, 2);
        exp_pc = exp_pc + 8'd2;
        got++;
        gap = 0;
        last = instr;
        if (got == 127) fetch_en = 1'b0;
      end else begin
        chk("R7 stream hold", instr, last);
      end
    end
    chk("R8 idle after stream", busy, 0);
    chk("R6 wrapped pc", pc, 8'd8);
    step();
    chk("R4 no extra pulse", instr_valid, 0);
  endtask

  initial begin
    exp_pc = 8'd0;
    t_reset();
    t_load();
    t_fetch_one("R2 loaded");
    t_blocked_writes();
    t_good_write();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule